// File: doc/BRIEF.md
# Signature-Driven Self-Test Pattern Engine

This block exercises a datapath unit under test without an external tester. Software or a test controller loads a run description made of four values: a starting state, a feedback tap mask, the number of patterns to apply and the signature a good unit should produce. A start pulse then launches a run. The engine steps a shift register whose feedback taps come from the mask, drives each new state to the unit as a stimulus pattern, and folds the unit's data result and its four status flags into a multiple-input signature register. Individual responses are never stored.

When the requested number of patterns has been applied, the engine raises a one-cycle completion strobe. At that point the pass output shows whether the compacted signature matches the expected value, and it holds that verdict until the next run starts. A tap mask of all zeros still runs, but a configuration-error output is raised, because such a mask can only shift in zeros.

Each pattern takes two cycles. In the first cycle the generator advances. In the second cycle the pattern is presented with a valid strobe and the unit's combinational response is captured at the closing clock edge.

Top module: `sig_selftest_engine`

## Requirements
- R1: After reset, busy, done, pass and patValid are low and cfgErr is high, because the stored tap mask resets to all zeros.
- R2: A cfgLoad pulse stores seed, mask, count and expected signature only while the engine is idle, with neither busy nor done high, and start low in the same cycle. A load at any other time has no effect on the running test or on later runs.
- R3: A start pulse while idle loads the generator with the stored seed, clears the signature register and the pass output, and raises busy (or done when the count is zero) in the next cycle. A start pulse while busy is ignored.
- R4: Each generator step computes a new bit as the XOR-reduction of (mask AND state). The state shifts right by one place and the new bit enters the most significant position. For a 3-bit generator with mask 3'b101 and seed 3'b011, the patterns are 5, 2, 1, 4, 6, 7, 3.
- R5: A run applies exactly count patterns, each being the state just after a step. Each pattern is presented on patOut for exactly one cycle with patValid high, and two cycles pass per pattern.
- R6: The response word is {4'b1111, overflow, carry, zero, negative, data}, with the flags at bits 11, 10, 9 and 8 of the 16-bit word. On each cycle with patValid high, the signature register updates to (sig << 1) ^ (sig[15] ? 16'h002D : 0) ^ response. At all other times it holds.
- R7: After the last capture, done is high for exactly one cycle. In that cycle, and until the next start, pass is high exactly when the final signature equals the expected value.
- R8: With a count of zero, no pattern is presented, done follows start by one cycle, and pass is high exactly when the expected value is zero.
- R9: cfgErr is high whenever the stored mask is all zeros. A run with such a mask still completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | Store the configuration buses |
| cfgSeed | input | GEN_W | Generator start state |
| cfgMask | input | GEN_W | Feedback tap mask |
| cfgCount | input | CNT_W | Number of patterns |
| cfgExpect | input | DATA_W+8 | Expected final signature |
| start | input | 1 | Launch a run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion strobe |
| pass | output | 1 | Signature matched expected value |
| cfgErr | output | 1 | Stored mask is all zeros |
| patOut | output | GEN_W | Stimulus pattern to the unit |
| patValid | output | 1 | patOut is a live pattern; response is captured this cycle |
| respData | input | DATA_W | Unit data result |
| respOvf | input | 1 | Unit overflow flag |
| respCarry | input | 1 | Unit carry flag |
| respZero | input | 1 | Unit zero flag |
| respNeg | input | 1 | Unit negative flag |

## Verification
The embedded properties check, on every cycle, the following behaviours:
- the completion strobe lasts a single cycle;
- a valid pattern only appears while busy;
- a start from idle always leads to busy or done;
- the configuration holds during a run;
- each generator step is a right shift with the parity of the masked state entering at the top;
- the signature only moves on capture cycles.

Only the directed scenarios can show the rest:
- the exact pattern sequence;
- the pattern count per run;
- the packing of the flags into the compacted response;
- the pass verdict against a computed signature;
- the zero-count and zero-mask cases;
- that loads and starts issued mid-run leave both the current and the following run unchanged.

// File: rtl/stpe_pkg.sv
package stpe_pkg;

  // status word: upper bits forced to one, four flags in the low nibble
  localparam int unsigned STAT_W = 8;
  localparam int unsigned FLAG_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STEP = 2'd1,
    ST_CAPT = 2'd2,
    ST_FIN  = 2'd3
  } stpe_state_t;

  typedef struct packed {
    logic loadCfg;   // latch configuration buses
    logic init;      // seed generator, clear signature and verdict
    logic step;      // advance generator
    logic capture;   // fold response into signature
    logic evalPass;  // form the verdict on this cycle
  } stpe_strobe_t;

endpackage

// File: rtl/stpe_ctrl.sv
module stpe_ctrl
  import stpe_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic             start,
  input  logic [CNT_W-1:0] countQ,
  output stpe_strobe_t     stb,
  output logic             busy,
  output logic             done,
  output logic             patValid
);

  stpe_state_t      stateQ, stateNxt;
  logic [CNT_W-1:0] remQ;
  logic             countIsZero;

  assign countIsZero = (countQ == '0);

  always_comb begin
    stb      = '0;
    stateNxt = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        stb.loadCfg = cfgLoad & ~start;
        if (start) begin
          stb.init = 1'b1;
          if (countIsZero) begin
            stb.evalPass = 1'b1;
            stateNxt     = ST_FIN;
          end else begin
            stateNxt = ST_STEP;
          end
        end
      end
      ST_STEP: begin
        stb.step = 1'b1;
        stateNxt = ST_CAPT;
      end
      ST_CAPT: begin
        stb.capture = 1'b1;
        if (remQ == {{(CNT_W-1){1'b0}}, 1'b1}) begin
          stb.evalPass = 1'b1;
          stateNxt     = ST_FIN;
        end else begin
          stateNxt = ST_STEP;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      remQ   <= '0;
    end else begin
      stateQ <= stateNxt;
      if (stateQ == ST_IDLE && start) begin
        remQ <= countQ;
      end else if (stateQ == ST_CAPT) begin
        remQ <= remQ - {{(CNT_W-1){1'b0}}, 1'b1};
      end
    end
  end

  assign busy     = (stateQ == ST_STEP) || (stateQ == ST_CAPT);
  assign done     = (stateQ == ST_FIN);
  assign patValid = (stateQ == ST_CAPT);

  // R7: completion strobe never lasts two cycles
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5: a generator step is only taken while patterns remain
  p_rem_live_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_STEP) |-> (remQ != '0));

endmodule

// File: rtl/stpe_dp.sv
module stpe_dp
  import stpe_pkg::*;
#(
  parameter int unsigned GEN_W  = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned SIG_W  = DATA_W + STAT_W,
  parameter logic [SIG_W-1:0] SIG_POLY = 'h002D
) (
  input  logic              clk,
  input  logic              rstN,
  input  stpe_strobe_t      stb,
  input  logic [GEN_W-1:0]  cfgSeed,
  input  logic [GEN_W-1:0]  cfgMask,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [SIG_W-1:0]  cfgExpect,
  input  logic [DATA_W-1:0] respData,
  input  logic              respOvf,
  input  logic              respCarry,
  input  logic              respZero,
  input  logic              respNeg,
  output logic [GEN_W-1:0]  patOut,
  output logic [CNT_W-1:0]  countQ,
  output logic              pass,
  output logic              cfgErr
);

  localparam int unsigned PAD_W = STAT_W - FLAG_W;

  logic [GEN_W-1:0] seedQ, maskQ, genQ, genNxt, tapProd;
  logic [SIG_W-1:0] expQ, misrQ, misrNxt, respWord, fbWord;
  logic             fbBit, passQ;

  // masked taps, one AND per state bit
  for (genvar g = 0; g < GEN_W; g++) begin : g_tap
    assign tapProd[g] = maskQ[g] & genQ[g];
  end

  assign fbBit  = ^tapProd;
  assign genNxt = {fbBit, genQ[GEN_W-1:1]};

  assign respWord = {{PAD_W{1'b1}}, respOvf, respCarry, respZero, respNeg, respData};
  assign fbWord   = misrQ[SIG_W-1] ? SIG_POLY : '0;
  assign misrNxt  = {misrQ[SIG_W-2:0], 1'b0} ^ fbWord ^ respWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seedQ  <= '0;
      maskQ  <= '0;
      countQ <= '0;
      expQ   <= '0;
      genQ   <= '0;
      misrQ  <= '0;
      passQ  <= 1'b0;
    end else begin
      if (stb.loadCfg) begin
        seedQ  <= cfgSeed;
        maskQ  <= cfgMask;
        countQ <= cfgCount;
        expQ   <= cfgExpect;
      end
      if (stb.init) begin
        genQ <= seedQ;
      end else if (stb.step) begin
        genQ <= genNxt;
      end
      if (stb.init) begin
        misrQ <= '0;
        passQ <= stb.evalPass && (expQ == '0);
      end else if (stb.capture) begin
        misrQ <= misrNxt;
        if (stb.evalPass) begin
          passQ <= (misrNxt == expQ);
        end
      end
    end
  end

  assign patOut = genQ;
  assign pass   = passQ;
  assign cfgErr = (maskQ == '0);

  // R4: a step is a right shift with the masked parity entering on top
  p_lfsr_shift_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |=> (genQ[GEN_W-2:0] == $past(genQ[GEN_W-1:1]))
                 && (genQ[GEN_W-1] == ^($past(genQ) & $past(maskQ))));

  // R6: the signature moves only on capture or init cycles
  p_misr_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.capture && !stb.init) |=> $stable(misrQ));

endmodule

// File: rtl/sig_selftest_engine.sv
module sig_selftest_engine
  import stpe_pkg::*;
#(
  parameter int unsigned GEN_W  = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16,
  parameter logic [DATA_W+STAT_W-1:0] SIG_POLY = 'h002D
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgLoad,
  input  logic [GEN_W-1:0]         cfgSeed,
  input  logic [GEN_W-1:0]         cfgMask,
  input  logic [CNT_W-1:0]         cfgCount,
  input  logic [DATA_W+STAT_W-1:0] cfgExpect,
  input  logic                     start,
  output logic                     busy,
  output logic                     done,
  output logic                     pass,
  output logic                     cfgErr,
  output logic [GEN_W-1:0]         patOut,
  output logic                     patValid,
  input  logic [DATA_W-1:0]        respData,
  input  logic                     respOvf,
  input  logic                     respCarry,
  input  logic                     respZero,
  input  logic                     respNeg
);

  localparam int unsigned SIG_W = DATA_W + STAT_W;

  stpe_strobe_t     stb;
  logic [CNT_W-1:0] countQ;

  stpe_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgLoad  (cfgLoad),
    .start    (start),
    .countQ   (countQ),
    .stb      (stb),
    .busy     (busy),
    .done     (done),
    .patValid (patValid)
  );

  stpe_dp #(
    .GEN_W    (GEN_W),
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W),
    .SIG_W    (SIG_W),
    .SIG_POLY (SIG_POLY)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cfgSeed   (cfgSeed),
    .cfgMask   (cfgMask),
    .cfgCount  (cfgCount),
    .cfgExpect (cfgExpect),
    .respData  (respData),
    .respOvf   (respOvf),
    .respCarry (respCarry),
    .respZero  (respZero),
    .respNeg   (respNeg),
    .patOut    (patOut),
    .countQ    (countQ),
    .pass      (pass),
    .cfgErr    (cfgErr)
  );

  // R2: stored configuration cannot change during a run
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(countQ));

  // R3: start from idle always leaves idle on the next cycle
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !done) |=> (busy || done));

  // R5: a pattern is only presented inside a run
  p_valid_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    patValid |-> busy);

endmodule

// File: tb/tb_sig_selftest_engine.sv
module tb_sig_selftest_engine;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN;
  logic        cfgLoad, start;
  logic [7:0]  cfgSeed, cfgMask;
  logic [15:0] cfgCount, cfgExpect;
  logic        busy, done, pass, cfgErr, patValid;
  logic [7:0]  patOut, respData;
  logic        respOvf, respCarry, respZero, respNeg;
  logic [15:0] rw;

  logic        c3Load, c3Start;
  logic [2:0]  c3Seed, c3Mask, c3Pat;
  logic [15:0] c3Count, c3Exp;
  logic        c3Busy, c3Done, c3Pass, c3Err, c3Valid;

  int checks = 0;
  int fails  = 0;

  function automatic logic [7:0] lfsrNext(input logic [7:0] q, input logic [7:0] m);
    return {^(q & m), q[7:1]};
  endfunction

  // model unit under test: add constant, derive flags
  function automatic logic [15:0] respOf(input logic [7:0] p);
    logic [7:0] d;
    d = p + 8'h37;
    return {4'hF, p[7] ^ p[6], (p > 8'hC8), (d == 8'h00), d[7], d};
  endfunction

  function automatic logic [15:0] misrStep(input logic [15:0] m, input logic [15:0] r);
    return {m[14:0], 1'b0} ^ (m[15] ? 16'h002D : 16'h0000) ^ r;
  endfunction

  function automatic logic [15:0] sigOf(input logic [7:0] s, input logic [7:0] m, input int n);
    logic [7:0]  q;
    logic [15:0] g;
    q = s;
    g = 16'h0;
    for (int i = 0; i < n; i++) begin
      q = lfsrNext(q, m);
      g = misrStep(g, respOf(q));
    end
    return g;
  endfunction

  assign rw        = respOf(patOut);
  assign respData  = rw[7:0];
  assign respNeg   = rw[8];
  assign respZero  = rw[9];
  assign respCarry = rw[10];
  assign respOvf   = rw[11];

  sig_selftest_engine dut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgSeed(cfgSeed), .cfgMask(cfgMask),
    .cfgCount(cfgCount), .cfgExpect(cfgExpect), .start(start), .busy(busy), .done(done),
    .pass(pass), .cfgErr(cfgErr), .patOut(patOut), .patValid(patValid),
    .respData(respData), .respOvf(respOvf), .respCarry(respCarry),
    .respZero(respZero), .respNeg(respNeg)
  );

  sig_selftest_engine #(.GEN_W(3)) dut3 (
    .clk(clk), .rstN(rstN), .cfgLoad(c3Load), .cfgSeed(c3Seed), .cfgMask(c3Mask),
    .cfgCount(c3Count), .cfgExpect(c3Exp), .start(c3Start), .busy(c3Busy), .done(c3Done),
    .pass(c3Pass), .cfgErr(c3Err), .patOut(c3Pat), .patValid(c3Valid),
    .respData(8'h00), .respOvf(1'b0), .respCarry(1'b0),
    .respZero(1'b0), .respNeg(1'b0)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic loadCfg(input logic [7:0] s, input logic [7:0] m,
                         input logic [15:0] n, input logic [15:0] e);
    @(negedge clk);
    cfgLoad = 1'b1; cfgSeed = s; cfgMask = m; cfgCount = n; cfgExpect = e;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  // evt: 0 plain, 1 start pulse mid-run, 2 load mid-run, 3 load with start
  task automatic runObs(input logic [7:0] s, input logic [7:0] m, input int evt,
                        output int nPat, output int badPat, output bit passAt,
                        output bit doneAfter, output bit gotDone);
    logic [7:0] q;
    q = s; nPat = 0; badPat = 0; passAt = 0; doneAfter = 0; gotDone = 0;
    @(negedge clk);
    start = 1'b1;
    if (evt == 3) begin
      cfgLoad = 1'b1; cfgSeed = 8'h11; cfgMask = 8'h03; cfgCount = 16'd2; cfgExpect = 16'h0;
    end
    @(negedge clk);
    start = 1'b0; cfgLoad = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if (evt == 1 && i == 3) start = 1'b1;
      if (evt == 1 && i == 4) start = 1'b0;
      if (evt == 2 && i == 3) begin
        cfgLoad = 1'b1; cfgSeed = 8'hFF; cfgMask = 8'h03; cfgCount = 16'd3; cfgExpect = 16'h0;
      end
      if (evt == 2 && i == 4) cfgLoad = 1'b0;
      if (patValid) begin
        nPat++;
        q = lfsrNext(q, m);
        if (patOut !== q) badPat++;
      end
      if (done) begin
        gotDone = 1'b1;
        passAt  = pass;
        @(negedge clk);
        doneAfter = done;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic tReset();
    chk(busy == 0 && done == 0 && patValid == 0, "R1", "busy/done/valid", {busy, done, patValid}, 0);
    chk(pass == 0, "R1", "pass", pass, 0);
    chk(cfgErr == 1, "R1", "cfgErr", cfgErr, 1);
  endtask

  task automatic tSeq3();
    logic [2:0] expSeq [7];
    int k;
    expSeq = '{3'd5, 3'd2, 3'd1, 3'd4, 3'd6, 3'd7, 3'd3};
    k = 0;
    @(negedge clk);
    c3Load = 1; c3Seed = 3'b011; c3Mask = 3'b101; c3Count = 16'd7; c3Exp = 16'h0;
    @(negedge clk);
    c3Load = 0; c3Start = 1;
    @(negedge clk);
    c3Start = 0;
    for (int i = 0; i < 100 && !c3Done; i++) begin
      if (c3Valid) begin
        if (k < 7) chk(c3Pat == expSeq[k], "R4", "3-bit pattern", c3Pat, expSeq[k]);
        k++;
      end
      @(negedge clk);
    end
    chk(k == 7, "R5", "3-bit pattern count", k, 7);
  endtask

  task automatic tMain(input logic [7:0] s, input logic [7:0] m, input int n);
    int np, bp; bit pa, da, gd;
    loadCfg(s, m, 16'(n), sigOf(s, m, n));
    chk(cfgErr == 0, "R9", "cfgErr nonzero mask", cfgErr, 0);
    runObs(s, m, 0, np, bp, pa, da, gd);
    chk(gd, "R7", "done seen", gd, 1);
    chk(np == n, "R5", "pattern count", np, n);
    chk(bp == 0, "R4", "pattern mismatches", bp, 0);
    chk(pa == 1, "R6", "pass with flag-packed signature", pa, 1);
    chk(da == 0, "R7", "done one cycle", da, 0);
    chk(pass == 1, "R7", "pass held after done", pass, 1);
  endtask

  task automatic tBadExpect();
    int np, bp; bit pa, da, gd;
    loadCfg(8'h5C, 8'h8E, 16'd12, sigOf(8'h5C, 8'h8E, 12) ^ 16'h0100);
    runObs(8'h5C, 8'h8E, 0, np, bp, pa, da, gd);
    chk(gd && pa == 0, "R7", "wrong expect fails", pa, 0);
  endtask

  task automatic tZeroCount();
    int np, bp; bit pa, da, gd;
    loadCfg(8'h42, 8'hB8, 16'd0, 16'h0000);
    runObs(8'h42, 8'hB8, 0, np, bp, pa, da, gd);
    chk(gd && np == 0, "R8", "zero count patterns", np, 0);
    chk(pa == 1, "R8", "zero count pass expect 0", pa, 1);
    loadCfg(8'h42, 8'hB8, 16'd0, 16'h0001);
    runObs(8'h42, 8'hB8, 0, np, bp, pa, da, gd);
    chk(gd && pa == 0, "R8", "zero count fail expect 1", pa, 0);
  endtask

  task automatic tZeroMask();
    int np, bp; bit pa, da, gd;
    loadCfg(8'hA5, 8'h00, 16'd9, sigOf(8'hA5, 8'h00, 9));
    chk(cfgErr == 1, "R9", "cfgErr zero mask", cfgErr, 1);
    runObs(8'hA5, 8'h00, 0, np, bp, pa, da, gd);
    chk(gd && np == 9 && bp == 0, "R9", "zero mask run", np, 9);
    chk(pa == 1, "R9", "zero mask pass", pa, 1);
  endtask

  task automatic tLoadBusy();
    int np, bp; bit pa, da, gd;
    loadCfg(8'h3A, 8'hB4, 16'd10, sigOf(8'h3A, 8'hB4, 10));
    runObs(8'h3A, 8'hB4, 2, np, bp, pa, da, gd);
    chk(np == 10 && pa == 1, "R2", "mid-run load ignored now", np, 10);
    runObs(8'h3A, 8'hB4, 0, np, bp, pa, da, gd);
    chk(np == 10 && bp == 0 && pa == 1, "R2", "mid-run load ignored later", np, 10);
    chk(cfgErr == 0, "R2", "mask kept", cfgErr, 0);
  endtask

  task automatic tStartBusy();
    int np, bp; bit pa, da, gd;
    runObs(8'h3A, 8'hB4, 1, np, bp, pa, da, gd);
    chk(np == 10 && pa == 1 && bp == 0, "R3", "start while busy ignored", np, 10);
    chk(busy == 0, "R3", "idle after run", busy, 0);
  endtask

  task automatic tLoadWithStart();
    int np, bp; bit pa, da, gd;
    runObs(8'h3A, 8'hB4, 3, np, bp, pa, da, gd);
    chk(np == 10 && pa == 1, "R2", "load with start uses old config", np, 10);
    runObs(8'h3A, 8'hB4, 0, np, bp, pa, da, gd);
    chk(np == 10 && pa == 1, "R2", "load with start discarded", np, 10);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rstN = 0; cfgLoad = 0; start = 0; cfgSeed = 0; cfgMask = 0; cfgCount = 0; cfgExpect = 0;
    c3Load = 0; c3Start = 0; c3Seed = 0; c3Mask = 0; c3Count = 0; c3Exp = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tSeq3();
    tMain(8'h01, 8'hB8, 20);
    tMain(8'hE7, 8'h1D, 57);
    tBadExpect();
    tZeroCount();
    tZeroMask();
    tLoadBusy();
    tStartBusy();
    tLoadWithStart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule